// File: doc/BRIEF.md
# SD Command and Response Engine

This block owns the command line of an SD host. Software places a 6-bit command index and a 32-bit argument on its inputs and then writes the control bits. The engine builds the 48-bit command frame and appends its CRC7. It shifts the frame out most significant bit first, one bit per clock, while it drives the output enable. When asked to, it then listens on the same line for the card's reply. The reply is either a 48-bit short response or a 136-bit long response.

A short reply is split into a 32-bit word and an 8-bit byte. Its CRC7 is always recomputed and compared, including for reply types that carry no CRC, so software decides whether to ignore the result. A long reply keeps its 120 payload bits and drops the CRC field and the end bit. A programmable counter limits the wait for the reply's start bit. The counter stops as soon as the start bit arrives, and a value of zero turns it off. The error flags are sticky and are cleared by write-one strobes. An engine reset aborts any operation without touching the captured results.

Top module: `sd_cmd_engine`

## Requirements
- R1: A command frame is, first bit to last: 0, 1, the 6-bit index, the 32-bit argument, the CRC7 of those 40 bits (generator x^7+x^3+1, register starting at zero), then 1. One bit is sent per clock. `cmdOe` is high for exactly 48 cycles, and `cmdOut` is 1 whenever `cmdOe` is low.
- R2: A control write with `ctlWData` bit 0 set arms the command. Bit 1 arms a short response, bit 2 arms a long response, and bit 3 requests an engine reset. Writing 0 to a bit has no effect. The command enable clears itself after the last frame bit. A response enable clears itself after the last reply bit or on a timeout.
- R3: The reply's start bit is the first 0 sampled on `cmdIn` once the command frame has ended. Bits are sampled one per clock from that point.
- R4: For a short reply, reply bits 47..16 go to `respWord` and bits 15..8 go to `respByte`.
- R5: On every short reply, `crcOk` becomes 1 if the CRC7 of bits 47..8 equals bits 7..1 and 0 otherwise. A mismatch also sets `crcErr`, whatever the reply type.
- R6: For a long reply (long enable, which wins over the short enable), bits 127..8 of the 136 bits go to `longWord`. `crcOk` and `crcErr` are left unchanged.
- R7: With `toutValue` N nonzero, a start bit in any of the first N samples is accepted. If none of the first N samples is 0, `toutErr` is set and both response enables clear.
- R8: With `toutValue` zero the engine waits for the start bit indefinitely and never sets `toutErr`.
- R9: `crcErr` and `toutErr` stay set until a `flagClr` strobe carries a 1 in `flagClrData` bit 0 (for `crcErr`) or bit 1 (for `toutErr`). A 0 in a bit leaves that flag set.
- R10: An engine reset returns the engine to idle and clears all three enables. It holds `engRstBusy` for RST_CYCLES cycles, during which enable writes are ignored. Result registers and flags keep their values.
- R11: After `rstN`, all enables, flags, results and `crcOk` are 0, and `cmdOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, one line bit per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWr | input | 1 | Control write strobe |
| ctlWData | input | 4 | Control write data: command, short reply, long reply, engine reset |
| flagClr | input | 1 | Flag clear strobe |
| flagClrData | input | 2 | Write-one-to-clear mask: bit 0 CRC error, bit 1 timeout |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| toutValue | input | 24 | Start-bit wait limit in cycles, 0 disables |
| cmdIn | input | 1 | Sampled command line from the card |
| cmdOut | output | 1 | Command line drive value |
| cmdOe | output | 1 | Command line drive enable |
| cmdBusy | output | 1 | Command enable bit |
| respBusy | output | 1 | Short reply enable bit |
| longBusy | output | 1 | Long reply enable bit |
| engRstBusy | output | 1 | Engine reset in progress |
| respWord | output | 32 | Short reply bits 47..16 |
| respByte | output | 8 | Short reply bits 15..8 |
| longWord | output | 120 | Long reply payload bits 127..8 |
| crcOk | output | 1 | Last short reply CRC7 matched |
| crcErr | output | 1 | Sticky CRC mismatch flag |
| toutErr | output | 1 | Sticky start-bit timeout flag |

## Verification
Every one of the 64 command indices is sent with an argument derived from the index. The captured frame is compared with a CRC7 computed by polynomial division in the bench, which separates a wrong generator, a wrong bit order or a wrong field position from a correct one. Three frames with well-known CRC bytes anchor that arithmetic. The replies in that sweep use start-bit gaps of 0 to 3 cycles and corrupt the CRC of every eighth reply, so word and byte slicing, CRC acceptance and the sticky flag are separated. A second sweep over small timeout values puts the start bit exactly at the last accepted sample, then one sample late, which exposes off-by-one limits. A long reply, a missing reply with the timeout disabled, zero writes and an engine reset during a wait cover the remaining enable and reset rules.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } engState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxStart;
    logic rxShift;
    logic shortDone;
    logic longDone;
    logic timeout;
  } dpStrobe_t;

  // one serial step of CRC7, generator x^7 + x^3 + 1
  function automatic logic [6:0] crc7Step(input logic [6:0] crc, input logic din);
    logic fb;
    fb = din ^ crc[6];
    return {crc[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  endfunction

endpackage

// File: rtl/sd_cmd_datapath.sv
module sd_cmd_datapath
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int LONG_BITS = 136
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  input  logic                  cmdOe,
  input  logic [IDX_W-1:0]      cmdIndex,
  input  logic [ARG_W-1:0]      cmdArg,
  input  logic                  cmdIn,
  input  logic                  flagClr,
  input  logic [1:0]            flagClrData,
  output logic                  cmdOut,
  output logic [ARG_W-1:0]      respWord,
  output logic [7:0]            respByte,
  output logic [LONG_BITS-17:0] longWord,
  output logic                  crcOk,
  output logic                  crcErr,
  output logic                  toutErr
);

  localparam int CMD_BITS = IDX_W + ARG_W + 10;
  localparam int SPAN     = CMD_BITS - 8;    // bits covered by CRC7
  localparam int RX_W     = LONG_BITS - 9;   // reply minus end bit and top byte

  logic [CMD_BITS-1:0] txReg;
  logic [RX_W-1:0]     rxReg;
  logic [SPAN-1:0]     txHead;
  logic [6:0]          txCrc;
  logic [6:0]          rxCrc;
  logic                crcMatch;

  assign txHead = {2'b01, cmdIndex, cmdArg};

  always_comb begin
    txCrc = '0;
    for (int i = SPAN - 1; i >= 0; i--) txCrc = crc7Step(txCrc, txHead[i]);
  end

  // at the last bit, rxReg holds every reply bit except the end bit
  always_comb begin
    rxCrc = '0;
    for (int i = CMD_BITS - 2; i >= 7; i--) rxCrc = crc7Step(rxCrc, rxReg[i]);
  end

  assign crcMatch = (rxCrc == rxReg[6:0]);
  assign cmdOut   = cmdOe ? txReg[CMD_BITS-1] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '1;
      rxReg    <= '0;
      respWord <= '0;
      respByte <= '0;
      longWord <= '0;
      crcOk    <= 1'b0;
      crcErr   <= 1'b0;
      toutErr  <= 1'b0;
    end else begin
      if (stb.txLoad)       txReg <= {txHead, txCrc, 1'b1};
      else if (stb.txShift) txReg <= {txReg[CMD_BITS-2:0], 1'b1};

      if (stb.rxStart || stb.rxShift) rxReg <= {rxReg[RX_W-2:0], cmdIn};

      if (stb.shortDone) begin
        respWord <= rxReg[CMD_BITS-2 -: ARG_W];
        respByte <= rxReg[CMD_BITS-2-ARG_W -: 8];
        crcOk    <= crcMatch;
      end
      if (stb.longDone) longWord <= rxReg[RX_W-1:7];

      if (stb.shortDone && !crcMatch)     crcErr <= 1'b1;
      else if (flagClr && flagClrData[0]) crcErr <= 1'b0;

      if (stb.timeout)                    toutErr <= 1'b1;
      else if (flagClr && flagClrData[1]) toutErr <= 1'b0;
    end
  end

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int TOUT_W     = 24,
  parameter int CMD_BITS   = 48,
  parameter int LONG_BITS  = 136,
  parameter int RST_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [3:0]        ctlWData,
  input  logic [TOUT_W-1:0] toutValue,
  input  logic              cmdIn,
  output dpStrobe_t         stb,
  output logic              cmdOe,
  output logic              cmdBusy,
  output logic              respBusy,
  output logic              longBusy,
  output logic              engRstBusy
);

  localparam int CNT_W = $clog2(LONG_BITS + 1);
  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);

  engState_t         state;
  logic              cmdEn, respEn, longEn, engRst;
  logic [RST_W-1:0]  rstCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [TOUT_W-1:0] waitCnt;
  logic              rstReq, live, lastBit, toHit;

  assign rstReq  = ctlWr && ctlWData[3];
  assign live    = !engRst && !rstReq;
  assign lastBit = (bitCnt == (longEn ? LONG_LAST : SHORT_LAST));
  assign toHit   = (toutValue != '0) && (waitCnt == toutValue - 1'b1);

  always_comb begin
    stb           = '0;
    stb.txLoad    = live && (state == ST_IDLE) && cmdEn;
    stb.txShift   = live && (state == ST_SEND);
    stb.rxStart   = live && (state == ST_WAIT) && !cmdIn;
    stb.timeout   = live && (state == ST_WAIT) && cmdIn && toHit;
    stb.rxShift   = live && (state == ST_RECV);
    stb.shortDone = stb.rxShift && lastBit && !longEn;
    stb.longDone  = stb.rxShift && lastBit && longEn;
  end

  assign cmdOe      = (state == ST_SEND);
  assign cmdBusy    = cmdEn;
  assign respBusy   = respEn;
  assign longBusy   = longEn;
  assign engRstBusy = engRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdEn   <= 1'b0;
      respEn  <= 1'b0;
      longEn  <= 1'b0;
      engRst  <= 1'b0;
      rstCnt  <= '0;
      bitCnt  <= '0;
      waitCnt <= '0;
    end else if (rstReq) begin
      state  <= ST_IDLE;
      cmdEn  <= 1'b0;
      respEn <= 1'b0;
      longEn <= 1'b0;
      engRst <= 1'b1;
      rstCnt <= RST_W'(RST_CYCLES - 1);
    end else if (engRst) begin
      if (rstCnt == '0) engRst <= 1'b0;
      else              rstCnt <= rstCnt - 1'b1;
    end else begin
      if (ctlWr) begin
        if (ctlWData[0]) cmdEn  <= 1'b1;
        if (ctlWData[1]) respEn <= 1'b1;
        if (ctlWData[2]) longEn <= 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (stb.txLoad) begin
            state  <= ST_SEND;
            bitCnt <= '0;
          end else if (respEn || longEn) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
          end
        end
        ST_SEND: begin
          if (bitCnt == SHORT_LAST) begin
            cmdEn   <= 1'b0;
            bitCnt  <= '0;
            waitCnt <= '0;
            state   <= (respEn || longEn) ? ST_WAIT : ST_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (stb.rxStart) begin
            state  <= ST_RECV;
            bitCnt <= CNT_W'(1);
          end else if (stb.timeout) begin
            state  <= ST_IDLE;
            respEn <= 1'b0;
            longEn <= 1'b0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RECV: begin
          if (lastBit) begin
            state  <= ST_IDLE;
            respEn <= 1'b0;
            longEn <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int TOUT_W     = 24,
  parameter int LONG_BITS  = 136,
  parameter int RST_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWr,
  input  logic [3:0]            ctlWData,
  input  logic                  flagClr,
  input  logic [1:0]            flagClrData,
  input  logic [IDX_W-1:0]      cmdIndex,
  input  logic [ARG_W-1:0]      cmdArg,
  input  logic [TOUT_W-1:0]     toutValue,
  input  logic                  cmdIn,
  output logic                  cmdOut,
  output logic                  cmdOe,
  output logic                  cmdBusy,
  output logic                  respBusy,
  output logic                  longBusy,
  output logic                  engRstBusy,
  output logic [ARG_W-1:0]      respWord,
  output logic [7:0]            respByte,
  output logic [LONG_BITS-17:0] longWord,
  output logic                  crcOk,
  output logic                  crcErr,
  output logic                  toutErr
);

  localparam int CMD_BITS = IDX_W + ARG_W + 10;

  dpStrobe_t stb;

  sd_cmd_ctrl #(
    .TOUT_W(TOUT_W), .CMD_BITS(CMD_BITS), .LONG_BITS(LONG_BITS), .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlWData(ctlWData),
    .toutValue(toutValue), .cmdIn(cmdIn), .stb(stb), .cmdOe(cmdOe),
    .cmdBusy(cmdBusy), .respBusy(respBusy), .longBusy(longBusy),
    .engRstBusy(engRstBusy)
  );

  sd_cmd_datapath #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .LONG_BITS(LONG_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdOe(cmdOe), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .cmdIn(cmdIn), .flagClr(flagClr), .flagClrData(flagClrData),
    .cmdOut(cmdOut), .respWord(respWord), .respByte(respByte), .longWord(longWord),
    .crcOk(crcOk), .crcErr(crcErr), .toutErr(toutErr)
  );

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rstN,
  input logic rstWr,
  input logic crcClr,
  input logic toClr,
  input logic toutOff,
  input logic cmdOut,
  input logic cmdOe,
  input logic cmdBusy,
  input logic respBusy,
  input logic longBusy,
  input logic engRstBusy,
  input logic crcOk,
  input logic crcErr,
  input logic toutErr
);

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !cmdOe |-> cmdOut);  // R1

  AST_FRAME_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> !cmdOut);  // R1

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdOe) |-> !cmdBusy);  // R2

  AST_CRC_FLAG_MEANS_BAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> !crcOk);  // R5

  AST_TIMEOUT_DROPS_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toutErr) |-> (!respBusy && !longBusy));  // R7

  AST_ZERO_LIMIT_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    toutOff |=> !$rose(toutErr));  // R8

  AST_CRC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !crcClr) |=> crcErr);  // R9

  AST_TIMEOUT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toutErr && !toClr) |=> toutErr);  // R9

  AST_ENGINE_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> (engRstBusy && !cmdBusy && !respBusy && !longBusy));  // R10

endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rstN(rstN),
  .rstWr(ctlWr && ctlWData[3]),
  .crcClr(flagClr && flagClrData[0]),
  .toClr(flagClr && flagClrData[1]),
  .toutOff(toutValue == '0),
  .cmdOut(cmdOut), .cmdOe(cmdOe), .cmdBusy(cmdBusy), .respBusy(respBusy),
  .longBusy(longBusy), .engRstBusy(engRstBusy), .crcOk(crcOk),
  .crcErr(crcErr), .toutErr(toutErr)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctlWr = 1'b0;
  logic [3:0]   ctlWData = '0;
  logic         flagClr = 1'b0;
  logic [1:0]   flagClrData = '0;
  logic [5:0]   cmdIndex = '0;
  logic [31:0]  cmdArg = '0;
  logic [23:0]  toutValue = 24'd10;
  logic         cmdIn = 1'b1;
  logic         cmdOut, cmdOe, cmdBusy, respBusy, longBusy, engRstBusy;
  logic [31:0]  respWord;
  logic [7:0]   respByte;
  logic [119:0] longWord;
  logic         crcOk, crcErr, toutErr;

  int checks = 0;
  int errors = 0;
  logic [47:0] lastFrame;

  always #2 clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlWData(ctlWData),
    .flagClr(flagClr), .flagClrData(flagClrData), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .toutValue(toutValue), .cmdIn(cmdIn), .cmdOut(cmdOut),
    .cmdOe(cmdOe), .cmdBusy(cmdBusy), .respBusy(respBusy), .longBusy(longBusy),
    .engRstBusy(engRstBusy), .respWord(respWord), .respByte(respByte),
    .longWord(longWord), .crcOk(crcOk), .crcErr(crcErr), .toutErr(toutErr)
  );

  // CRC7 by long division with generator 1_0001001
  function automatic logic [6:0] refCrc(input logic [39:0] msg);
    logic [46:0] r;
    r = {msg, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [3:0] d);
    @(negedge clk); ctlWr = 1'b1; ctlWData = d;
    @(negedge clk); ctlWr = 1'b0; ctlWData = '0;
  endtask

  task automatic clearFlags(input logic [1:0] m);
    @(negedge clk); flagClr = 1'b1; flagClrData = m;
    @(negedge clk); flagClr = 1'b0; flagClrData = '0;
  endtask

  // mode 0 short, 1 short with bad CRC, 2 long, 3 no reply (gap = limit)
  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg,
                        input logic [31:0] rArg, input int gap, input int mode);
    logic [47:0]  expFrame, cap, rFrame;
    logic [135:0] lFrame;
    logic [119:0] pay;
    logic         prevOk;
    int           n;
    cmdIndex = idx; cmdArg = arg;
    expFrame = {2'b01, idx, arg, refCrc({2'b01, idx, arg}), 1'b1};
    prevOk = crcOk;
    ctlWrite(mode == 2 ? 4'b0101 : 4'b0011);
    check("R2", cmdBusy, 1, "command enable set by write");
    @(negedge clk);
    n = 0; cap = '0;
    while (cmdOe && n < 60) begin
      cap = {cap[46:0], cmdOut};
      n++;
      @(negedge clk);
    end
    lastFrame = cap;
    check("R1", n, 48, "frame length");
    check("R1", cap, expFrame, "frame bits");
    check("R2", cmdBusy, 0, "command enable self-clear");
    if (mode == 3) begin
      for (int j = 0; j < gap; j++) begin
        if (j == gap - 1) check("R7", toutErr, 0, "no timeout at last legal sample");
        @(negedge clk);
      end
      check("R7", toutErr, 1, "timeout flag");
      check("R7", respBusy, 0, "enable dropped on timeout");
      clearFlags(2'b10);
      check("R9", toutErr, 0, "timeout flag cleared");
    end else begin
      for (int j = 0; j < gap; j++) @(negedge clk);
      if (mode == 2) begin
        pay = {rArg, rArg ^ 32'hFFFF0000, ~rArg, rArg[23:0]};
        lFrame = {2'b00, 6'h3F, pay, 7'h55, 1'b1};
        for (int k = 135; k >= 0; k--) begin cmdIn = lFrame[k]; @(negedge clk); end
        cmdIn = 1'b1;
        check("R6", longWord, pay, "long payload");
        check("R6", crcOk, prevOk, "crcOk untouched by long reply");
        check("R2", longBusy, 0, "long enable self-clear");
      end else begin
        rFrame = {2'b00, idx, rArg, 8'h00};
        rFrame[7:0] = {refCrc(rFrame[47:8]) ^ ((mode == 1) ? 7'h01 : 7'h00), 1'b1};
        for (int k = 47; k >= 0; k--) begin cmdIn = rFrame[k]; @(negedge clk); end
        cmdIn = 1'b1;
        check("R3", respWord, rFrame[47:16], "reply word after start gap");
        check("R4", respByte, rFrame[15:8], "reply byte");
        check("R5", crcOk, (mode == 0), "crc ok status");
        check("R5", crcErr, (mode == 1), "crc error flag");
        check("R2", respBusy, 0, "reply enable self-clear");
        check("R7", toutErr, 0, "no timeout when start in window");
        if (mode == 1) begin
          clearFlags(2'b00);
          check("R9", crcErr, 1, "zero clear keeps flag");
          clearFlags(2'b01);
          check("R9", crcErr, 0, "one clears flag");
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] keepWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", {cmdOut, cmdOe, cmdBusy, respBusy, longBusy, engRstBusy}, 6'b100000, "control reset");
    check("R11", {crcOk, crcErr, toutErr}, 3'b000, "status reset");
    check("R11", {respWord, respByte, longWord}, '0, "results reset");

    // known vectors
    runCmd(6'd0, 32'h0, 32'h0, 1, 0);
    check("R1", lastFrame, 48'h400000000095, "index 0 vector");
    runCmd(6'd8, 32'h000001AA, 32'h000001AA, 0, 0);
    check("R1", lastFrame, 48'h48000001AA87, "index 8 vector");
    runCmd(6'd17, 32'h0, 32'h00000900, 2, 0);
    check("R1", lastFrame, 48'h510000000055, "index 17 vector");

    // full index sweep
    for (int i = 0; i < 64; i++) begin
      runCmd(6'(i), 32'(i) * 32'h9E3779B1 + 32'h13, 32'(i) * 32'h01000193 ^ 32'hA5A50000,
             i % 4, (i % 8 == 7) ? 1 : 0);
    end

    // long reply
    runCmd(6'd2, 32'h0, 32'hC0FFEE11, 1, 2);

    // timeout window edges
    for (int t = 1; t <= 5; t++) begin
      toutValue = 24'(t);
      runCmd(6'(t + 40), 32'(t) << 20, 32'hFACE0000 | 32'(t), t - 1, 0);
      runCmd(6'(t + 50), 32'(t), 32'h0, t, 3);
    end

    // limit zero: waits forever, zero writes ignored, engine reset recovers
    toutValue = '0;
    keepWord = respWord;
    cmdIndex = 6'd55; cmdArg = 32'h1;
    ctlWrite(4'b0011);
    repeat (400) @(negedge clk);
    check("R8", respBusy, 1, "still waiting with limit zero");
    check("R8", toutErr, 0, "no timeout with limit zero");
    ctlWrite(4'b0000);
    check("R2", respBusy, 1, "zero write has no effect");
    ctlWrite(4'b1000);
    check("R10", {engRstBusy, respBusy, cmdBusy, longBusy}, 4'b1000, "reset aborts wait");
    ctlWrite(4'b0010);
    check("R10", respBusy, 0, "enable write ignored during reset");
    check("R10", engRstBusy, 1, "reset busy third cycle");
    @(negedge clk);
    check("R10", engRstBusy, 0, "reset busy released");
    check("R10", respWord, keepWord, "results kept across reset");
    check("R1", {cmdOe, cmdOut}, 2'b01, "line idle after reset");

    toutValue = 24'd10;
    runCmd(6'd13, 32'h12345678, 32'h0BADCAFE, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule